// File: doc/BRIEF.md
# Decimation-in-Frequency Cosine Butterfly Engine

This block runs the decimation-in-frequency part of a fast one-dimensional cosine transform. It works on N = 2^n real fixed-point samples held in one internal in-place sample store. The host loads the samples through a simple word port while the engine is idle and pulses `start`. The engine then runs n stages. In each stage it issues one butterfly per clock. Every butterfly reads a pair of samples and writes two results back over the same two locations: their sum, and their difference multiplied by a cosine weight. When the last result of the final stage is stored, the engine pulses `done`, and the host reads the transformed values back through the same port.

The weights come from an internal table that is computed at elaboration. In stage j the group length is Nj = 2^(n-j+1). A butterfly at offset t inside its group, with 0 <= t < Nj/2, uses the weight 2cos(2π(t+1/4)/Nj). The weight is stored as a signed word with two integer bits. Between stages the engine waits two cycles so that the next stage reads fully updated data.

Top module: `dct_dif_engine`

## Requirements
- R1: After a synchronous reset, `busy` and `done` are both 0.
- R2: A `start` pulse seen while idle makes `busy` 1 on the next cycle. `busy` stays 1 without a gap until the run ends.
- R3: A run performs exactly n stages. In stage j (1..n) the two operands of every butterfly lie 2^(n-j) addresses apart: first address = g·2^(n-j+1) + t, second = first + 2^(n-j).
- R4: Each butterfly writes x1 + x2, saturated to the sample width, to the first address.
- R5: Each butterfly writes ((x1 − x2)·C + 2^(F−1)) >> F to the second address. The shift is arithmetic (floor). F = CW − 2, and C = floor(2cos(2π(t+1/4)/Nj)·2^F + 0.5).
- R6: Both results saturate to the signed range of the sample width instead of wrapping.
- R7: `done` is 1 for exactly one cycle. It is first seen n·(N/2 + 2) clock edges after the edge that samples `start`, and `busy` is 0 while `done` is 1.
- R8: `host_rdata` shows the word at `host_addr` one cycle after the address is presented. Host writes and `start` pulses made while `busy` is 1 have no effect.
- R9: Results stay in place, so a second `start` without reloading transforms the output of the first run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (ignored while busy) |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse after the final write |
| host_we | input | 1 | Write `host_wdata` into the sample store (idle only) |
| host_addr | input | LOG2N | Sample address for host read and write |
| host_wdata | input | DW | Sample to write |
| host_rdata | output | DW | Registered sample read from `host_addr` |

## Verification
The hardest case to reach from the ports is a run that is disturbed while it is in progress. The host write and the second `start` must not land in the sample store or restart the sequencer. The bench reaches this state by raising both in the middle of stage 1 and then comparing every output word and the `done` timing with an undisturbed reference. Saturation inside deep stages is reached by loading full-scale and alternating-sign patterns. Chained runs without a reload show that results stay in place.

// File: rtl/dct_pkg.sv
package dct_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_DRAIN
  } eng_state_e;

  // pi scaled by 2^28
  localparam longint PI_Q28 = 64'sd843314857;

  // cosine of a Q28 angle in [0, pi], Taylor series in integer arithmetic
  function automatic longint cos_q28(input longint ang);
    longint x2;
    longint term;
    longint acc;
    x2   = (ang * ang) >>> 28;
    term = longint'(1) <<< 28;
    acc  = term;
    for (int k = 1; k <= 12; k++) begin
      term = -((term * x2) >>> 28) / longint'((2 * k - 1) * (2 * k));
      acc  = acc + term;
    end
    return acc;
  endfunction

  // weight 2cos(2*pi*(t+1/4)/Nj) with fb fraction bits, Nj = 2^(lg-j+1)
  function automatic longint coef_word(input int lg, input int j, input int t, input int fb);
    longint nj;
    longint ang;
    longint c;
    longint v;
    longint lim;
    nj  = longint'(1) <<< (lg - j + 1);
    ang = (PI_Q28 * longint'(4 * t + 1)) / (2 * nj);
    c   = cos_q28(ang);
    v   = ((c <<< (fb + 1)) + (longint'(1) <<< 27)) >>> 28;
    lim = (longint'(1) <<< (fb + 1)) - 1;
    if (v > lim) v = lim;
    if (v < -lim) v = -lim;
    return v;
  endfunction

endpackage

// File: rtl/dct_coef_rom.sv
module dct_coef_rom #(
  parameter int LOG2N = 4,
  parameter int CW    = 16
) (
  input  logic                                 clk,
  input  logic [(LOG2N > 1 ? $clog2(LOG2N) : 1)-1:0] stage,
  input  logic [LOG2N-2:0]                     tidx,
  output logic signed [CW-1:0]                 coef
);
  localparam int N  = 1 << LOG2N;
  localparam int AW = LOG2N;
  localparam int FB = CW - 2;

  // stage s (0-based) owns entries [N - 2^(LOG2N-s), N - 2^(LOG2N-s-1))
  logic signed [CW-1:0] tab [N-1];

  for (genvar gs = 0; gs < LOG2N; gs++) begin : g_stage
    localparam int CNT  = 1 << (LOG2N - 1 - gs);
    localparam int BASE = N - (1 << (LOG2N - gs));
    for (genvar gt = 0; gt < CNT; gt++) begin : g_tw
      assign tab[BASE+gt] = CW'(dct_pkg::coef_word(LOG2N, gs + 1, gt, FB));
    end
  end

  logic [AW-1:0] idx;
  always_comb begin
    idx = AW'(N - (1 << (LOG2N - int'(stage)))) + AW'(tidx);
  end

  always_ff @(posedge clk) begin
    coef <= tab[idx];
  end

endmodule

// File: rtl/dct_stage_ctrl.sv
module dct_stage_ctrl #(
  parameter int LOG2N = 4
) (
  input  logic                                       clk,
  input  logic                                       rst,
  input  logic                                       start,
  output logic                                       busy,
  output logic                                       done,
  output logic                                       issue,
  output logic [LOG2N-1:0]                           rd_a,
  output logic [LOG2N-1:0]                           rd_b,
  output logic [(LOG2N > 1 ? $clog2(LOG2N) : 1)-1:0] stage,
  output logic [LOG2N-2:0]                           tidx
);
  import dct_pkg::*;

  localparam int AW = LOG2N;
  localparam int SW = (LOG2N > 1) ? $clog2(LOG2N) : 1;
  localparam int BW = LOG2N - 1;

  eng_state_e     st_q;
  logic [SW-1:0]  stage_q;
  logic [BW-1:0]  bcnt_q;
  logic           dcnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      stage_q <= '0;
      bcnt_q  <= '0;
      dcnt_q  <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            st_q    <= ST_RUN;
            stage_q <= '0;
            bcnt_q  <= '0;
          end
        end
        ST_RUN: begin
          if (&bcnt_q) begin
            st_q   <= ST_DRAIN;
            dcnt_q <= 1'b0;
          end
          bcnt_q <= bcnt_q + 1'b1;
        end
        ST_DRAIN: begin
          dcnt_q <= 1'b1;
          if (dcnt_q) begin
            if (stage_q == SW'(LOG2N - 1)) begin
              st_q    <= ST_IDLE;
              stage_q <= '0;
              done    <= 1'b1;
            end else begin
              st_q    <= ST_RUN;
              stage_q <= stage_q + 1'b1;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy  = (st_q != ST_IDLE);
  assign issue = (st_q == ST_RUN);
  assign stage = stage_q;

  // pair addressing for the current butterfly
  logic [AW-1:0] half;
  logic [AW-1:0] bext;
  logic [AW-1:0] toff;
  logic [AW-1:0] grp;
  int            shv;
  always_comb begin
    shv  = LOG2N - 1 - int'(stage_q);
    half = AW'(1) << shv;
    bext = AW'(bcnt_q);
    toff = bext & (half - 1'b1);
    grp  = bext >> shv;
    rd_a = (grp << (shv + 1)) | toff;
    rd_b = rd_a | half;
    tidx = toff[BW-1:0];
  end

  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (rst) (start && !busy) |=> busy); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst) done |-> !busy); // R7
  AST_STAGE_STEP: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && stage_q != $past(stage_q)) |-> (stage_q == SW'($past(stage_q) + 1'b1))); // R3

endmodule

// File: rtl/dct_bfly_pe.sv
module dct_bfly_pe #(
  parameter int LOG2N = 4,
  parameter int DW    = 16,
  parameter int CW    = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_vld,
  input  logic signed [DW-1:0] in_a,
  input  logic signed [DW-1:0] in_b,
  input  logic [LOG2N-1:0]     in_ia,
  input  logic [LOG2N-1:0]     in_ib,
  input  logic signed [CW-1:0] coef,
  output logic                 out_vld,
  output logic signed [DW-1:0] out_sum,
  output logic signed [DW-1:0] out_dif,
  output logic [LOG2N-1:0]     out_ia,
  output logic [LOG2N-1:0]     out_ib
);
  localparam int FB = CW - 2;
  localparam int PW = DW + 1 + CW;
  localparam logic signed [PW-1:0] PMAX = PW'((64'sd1 <<< (DW - 1)) - 1);
  localparam logic signed [PW-1:0] PMIN = -PW'(64'sd1 <<< (DW - 1));
  localparam logic signed [PW-1:0] HALF_LSB = PW'(64'sd1 <<< (FB - 1));

  // operand stage: aligned with the registered coefficient
  logic                 a_vld;
  logic signed [DW-1:0] a_q;
  logic signed [DW-1:0] b_q;
  logic [LOG2N-1:0]     ia_q;
  logic [LOG2N-1:0]     ib_q;

  always_ff @(posedge clk) begin
    if (rst) a_vld <= 1'b0;
    else     a_vld <= in_vld;
    a_q  <= in_a;
    b_q  <= in_b;
    ia_q <= in_ia;
    ib_q <= in_ib;
  end

  logic signed [DW:0]   sum_w;
  logic signed [DW:0]   dif_w;
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] scaled;
  logic signed [DW-1:0] sum_s;
  logic signed [DW-1:0] dif_s;

  always_comb begin
    sum_w  = {a_q[DW-1], a_q} + {b_q[DW-1], b_q};
    dif_w  = {a_q[DW-1], a_q} - {b_q[DW-1], b_q};
    prod   = PW'(dif_w) * PW'(coef);
    scaled = (prod + HALF_LSB) >>> FB;
    if (sum_w[DW] != sum_w[DW-1])
      sum_s = sum_w[DW] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
    else
      sum_s = sum_w[DW-1:0];
    if (scaled > PMAX)      dif_s = PMAX[DW-1:0];
    else if (scaled < PMIN) dif_s = PMIN[DW-1:0];
    else                    dif_s = scaled[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) out_vld <= 1'b0;
    else     out_vld <= a_vld;
    out_sum <= sum_s;
    out_dif <= dif_s;
    out_ia  <= ia_q;
    out_ib  <= ib_q;
  end

  AST_SUM_NONNEG: assert property (@(posedge clk) disable iff (rst)
    (a_vld && a_q >= 0 && b_q >= 0) |=> (out_sum >= 0)); // R6
  AST_SUM_NONPOS: assert property (@(posedge clk) disable iff (rst)
    (a_vld && a_q < 0 && b_q < 0) |=> (out_sum < 0)); // R6
  AST_ZERO_DIFF: assert property (@(posedge clk) disable iff (rst)
    (a_vld && a_q == b_q) |=> (out_dif == 0)); // R5

endmodule

// File: rtl/dct_dif_engine.sv
module dct_dif_engine #(
  parameter int LOG2N = 4,
  parameter int DW    = 16,
  parameter int CW    = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  output logic                 busy,
  output logic                 done,
  input  logic                 host_we,
  input  logic [LOG2N-1:0]     host_addr,
  input  logic signed [DW-1:0] host_wdata,
  output logic signed [DW-1:0] host_rdata
);
  localparam int N  = 1 << LOG2N;
  localparam int AW = LOG2N;
  localparam int SW = (LOG2N > 1) ? $clog2(LOG2N) : 1;

  logic                 issue;
  logic [AW-1:0]        rd_a;
  logic [AW-1:0]        rd_b;
  logic [SW-1:0]        stage;
  logic [LOG2N-2:0]     tidx;
  logic signed [CW-1:0] coef;
  logic                 wr_vld;
  logic signed [DW-1:0] wr_sum;
  logic signed [DW-1:0] wr_dif;
  logic [AW-1:0]        wr_ia;
  logic [AW-1:0]        wr_ib;

  logic signed [DW-1:0] mem [N];

  dct_stage_ctrl #(.LOG2N(LOG2N)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .busy  (busy),
    .done  (done),
    .issue (issue),
    .rd_a  (rd_a),
    .rd_b  (rd_b),
    .stage (stage),
    .tidx  (tidx)
  );

  dct_coef_rom #(.LOG2N(LOG2N), .CW(CW)) u_rom (
    .clk   (clk),
    .stage (stage),
    .tidx  (tidx),
    .coef  (coef)
  );

  dct_bfly_pe #(.LOG2N(LOG2N), .DW(DW), .CW(CW)) u_pe (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (issue),
    .in_a    (mem[rd_a]),
    .in_b    (mem[rd_b]),
    .in_ia   (rd_a),
    .in_ib   (rd_b),
    .coef    (coef),
    .out_vld (wr_vld),
    .out_sum (wr_sum),
    .out_dif (wr_dif),
    .out_ia  (wr_ia),
    .out_ib  (wr_ib)
  );

  // in-place sample store: host port when idle, butterfly results when running
  always_ff @(posedge clk) begin
    if (wr_vld) begin
      mem[wr_ia] <= wr_sum;
      mem[wr_ib] <= wr_dif;
    end else if (host_we && !busy) begin
      mem[host_addr] <= host_wdata;
    end
    host_rdata <= mem[host_addr];
  end

  AST_WR_PAIR_SPLIT: assert property (@(posedge clk) disable iff (rst) wr_vld |-> (wr_ia != wr_ib)); // R3
  AST_WR_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst) wr_vld |-> busy); // R8

endmodule

// File: tb/dct_dif_engine_tb.sv
`timescale 1ns/1ps
module dct_dif_engine_tb;
  localparam int LG  = 4;
  localparam int N   = 1 << LG;
  localparam int DW  = 16;
  localparam int CW  = 16;
  localparam int FB  = CW - 2;
  localparam int LAT = LG * (N / 2 + 2);

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 start = 1'b0;
  logic                 host_we = 1'b0;
  logic [LG-1:0]        host_addr = '0;
  logic signed [DW-1:0] host_wdata = '0;
  logic                 busy;
  logic                 done;
  logic signed [DW-1:0] host_rdata;

  int total = 0;
  int bad   = 0;
  int seed  = 12345;
  longint ref_v [N];

  always #2 clk = ~clk;

  dct_dif_engine #(.LOG2N(LG), .DW(DW), .CW(CW)) u_dut (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint sat(input longint v);
    longint mx = (longint'(1) <<< (DW - 1)) - 1;
    if (v > mx) return mx;
    if (v < -mx - 1) return -mx - 1;
    return v;
  endfunction

  function automatic longint wgt(input int j, input int t);
    real nj;
    real x;
    nj = real'(1 << (LG - j + 1));
    x  = 2.0 * $cos(2.0 * 3.14159265358979 * (real'(t) + 0.25) / nj) * real'(1 << FB);
    return longint'($floor(x + 0.5));
  endfunction

  // reference of the stage recursion (R3, R4, R5, R6)
  task automatic model();
    for (int j = 1; j <= LG; j++) begin
      int half = 1 << (LG - j);
      for (int b = 0; b < N / 2; b++) begin
        int t  = b % half;
        int ia = (b / half) * 2 * half + t;
        int ib = ia + half;
        longint x1 = ref_v[ia];
        longint x2 = ref_v[ib];
        ref_v[ia] = sat(x1 + x2);
        ref_v[ib] = sat(((x1 - x2) * wgt(j, t) + (longint'(1) <<< (FB - 1))) >>> FB);
      end
    end
  endtask

  task automatic load_all();
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      host_we    = 1'b1;
      host_addr  = LG'(i);
      host_wdata = DW'(ref_v[i]);
    end
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic run(input bit disturb);
    int  cnt  = 0;
    bit  seen = 0;
    bit  gap  = 0;
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    while (!seen && cnt < 400) begin
      @(posedge clk);
      cnt++;
      #1;
      if (done) seen = 1;
      else if (!busy) gap = 1;
      if (disturb && cnt == 5) begin
        host_we = 1'b1; host_addr = '0; host_wdata = 16'sh1234; start = 1'b1;
      end else if (disturb && cnt == 6) begin
        host_we = 1'b0; start = 1'b0;
      end
    end
    check("R7", "done latency", cnt, LAT);
    check("R2", "busy gap before done", gap, 0);
    check("R7", "busy while done", busy, 0);
    @(posedge clk);
    #1 check("R7", "done pulse width", done, 0);
  endtask

  task automatic readback(input string req);
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      host_addr = LG'(i);
      @(posedge clk);
      #1 check(req, $sformatf("word %0d", i), host_rdata, ref_v[i]);
    end
  endtask

  task automatic one_pass(input string req, input bit disturb);
    load_all();
    model();
    run(disturb);
    readback(req);
  endtask

  function automatic longint rnd(input longint lo, input longint hi);
    seed = seed * 1103515245 + 12345;
    return lo + longint'((seed >>> 8) & 32'h7fffff) % (hi - lo + 1);
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1", "busy after reset", busy, 0);
    check("R1", "done after reset", done, 0);

    for (int i = 0; i < N; i++) ref_v[i] = 0;
    one_pass("R4,R5 zeros", 0);

    // impulse at every position exercises every pair distance (R3)
    for (int p = 0; p < N; p++) begin
      for (int i = 0; i < N; i++) ref_v[i] = (i == p) ? 1000 : 0;
      one_pass("R3,R5 impulse", 0);
    end

    for (int i = 0; i < N; i++) ref_v[i] = i * 100 - 700;
    one_pass("R4,R5 ramp", 0);

    // full-scale patterns force saturation (R6)
    for (int i = 0; i < N; i++) ref_v[i] = 32767;
    one_pass("R6 all max", 0);
    for (int i = 0; i < N; i++) ref_v[i] = (i % 2) ? -32768 : 32767;
    one_pass("R6 alternating", 0);
    for (int i = 0; i < N; i++) ref_v[i] = (i < N / 2) ? 30000 : -30000;
    one_pass("R6 halves", 0);

    for (int r = 0; r < 6; r++) begin
      for (int i = 0; i < N; i++) ref_v[i] = rnd(-32768, 32767);
      one_pass("R4,R5,R6 random wide", 0);
    end
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < N; i++) ref_v[i] = rnd(-500, 500);
      one_pass("R4,R5 random small", 0);
    end

    // host write and start while busy must be ignored (R8)
    for (int i = 0; i < N; i++) ref_v[i] = rnd(-2000, 2000);
    one_pass("R8 busy disturb", 1);

    // chained runs on the stored results (R9)
    for (int i = 0; i < N; i++) ref_v[i] = rnd(-300, 300);
    load_all();
    model();
    run(0);
    model();
    run(0);
    readback("R9 chained");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule